// File: doc/BRIEF.md
# Priority register-access arbiter

This block lets three memory-mapped masters share the programmable register space of one channel. Master 0 is an embedded configuration streamer, master 1 is a user reconfiguration port and master 2 is a debug master. Each master starts an access by raising read or write on its port. The arbiter forwards exactly one granted access at a time to a single downstream register port. Masters that are not being served see waitrequest held high.

Priority is fixed: master 0 first, then master 1, then master 2. An access that has been granted always runs to completion, even if a more important master asks in the meantime. After every completed access the arbiter spends one idle cycle and picks a winner again from scratch.

Grants are only issued while the calibration engine does not own the configuration bus. A handback request from the surrounding logic blocks new grants. Its acknowledge is raised only once the arbiter is idle, so ownership can be returned safely.

Top module: `reg_access_arbiter`

## Requirements
- R1: When several enabled masters request in the same idle cycle, the lowest-indexed one wins. Index 0 (streamer) beats index 1 (user port), which beats index 2 (debug).
- R2: A granted access is never preempted. A higher-priority master that requests during it keeps waitrequest high until that access completes.
- R3: While `cal_owns` is high, no grant is made and no downstream read or write is issued. All masters see waitrequest high.
- R4: A master whose bit in `m_enable` is 0 never receives a grant, and its requests cause no downstream access.
- R5: While `handback_req` is high, no new grant is made. `handback_ack` rises one cycle after a cycle in which `handback_req` was high and the arbiter was idle. It falls one cycle after `handback_req` falls.
- R6: A write completes in a cycle where `s_write` is high and `s_wait` is low. A read completes in a cycle where `s_read` is high and `s_rvalid` is high. Only in that cycle does the granted master see its waitrequest low. In the next cycle the grant is released and no downstream access is driven.
- R7: Each master's readdata equals `s_rdata` while that master is granted and is zero otherwise.
- R8: After each completion, arbitration is evaluated anew in the following idle cycle. A higher-priority master that waited therefore wins over a lower-priority master that requests again straight away.
- R9: A synchronous active-high reset makes the arbiter idle, clears the grant, drives all waitrequests high and deasserts `handback_ack`, even in the middle of an access.
- R10: A grant takes effect one cycle after the idle cycle in which it is decided. While granted, `s_addr` and `s_wdata` carry the granted master's address and write data. With no grant they are zero. If a master raises read and write together, the write is performed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| m_enable | input | 3 | Per-master participation enable |
| m_read | input | 3 | Per-master read request |
| m_write | input | 3 | Per-master write request |
| m_addr | input | 3*ADDR_W | Per-master address, master i in slice i |
| m_wdata | input | 3*DATA_W | Per-master write data, master i in slice i |
| m_rdata | output | 3*DATA_W | Per-master read data, master i in slice i |
| m_wait | output | 3 | Per-master waitrequest |
| cal_owns | input | 1 | Calibration engine currently owns the configuration bus |
| handback_req | input | 1 | Request to return the bus to the calibration engine |
| handback_ack | output | 1 | Arbiter is idle and the bus may be handed back |
| s_addr | output | ADDR_W | Downstream address |
| s_wdata | output | DATA_W | Downstream write data |
| s_read | output | 1 | Downstream read |
| s_write | output | 1 | Downstream write |
| s_rdata | input | DATA_W | Downstream read data |
| s_rvalid | input | 1 | Downstream read data valid |
| s_wait | input | 1 | Downstream waitrequest |

## Verification
A corrupted grant register would show up at once, in the cycle after the idle decision. The symptoms would be the wrong address on `s_addr`, a downstream strobe of the wrong kind, or waitrequest dropping for a master that was not served. A stuck busy state would leave every waitrequest high and keep `handback_ack` low indefinitely. A missed release would drive a second downstream strobe in the cycle after completion. Each of these appears within one or two cycles of the faulty transition, which is why the bench checks every cycle of its sequences.

// File: rtl/arb_pkg.sv
package arb_pkg;
    localparam int NUM_M = 3;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_BUSY = 1'b1
    } arb_state_e;

    typedef struct packed {
        arb_state_e       state;
        logic [NUM_M-1:0] gnt;
        logic             op_wr;
        logic             ack;
    } arb_regs_t;
endpackage

// File: rtl/arb_prio_pick.sv
module arb_prio_pick #(
    parameter int N = 3
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] pick
);
    // index 0 is most important
    for (genvar i = 0; i < N; i++) begin : g_pick
        if (i == 0) begin : g_top
            assign pick[i] = req[i];
        end else begin : g_rest
            assign pick[i] = req[i] & ~(|req[i-1:0]);
        end
    end
endmodule

// File: rtl/arb_port_mux.sv
module arb_port_mux #(
    parameter int N      = 3,
    parameter int ADDR_W = 10,
    parameter int DATA_W = 32
) (
    input  logic [N-1:0]        gnt,
    input  logic                xfer_done,
    input  logic [N*ADDR_W-1:0] m_addr,
    input  logic [N*DATA_W-1:0] m_wdata,
    input  logic [DATA_W-1:0]   s_rdata,
    output logic [ADDR_W-1:0]   s_addr,
    output logic [DATA_W-1:0]   s_wdata,
    output logic [N*DATA_W-1:0] m_rdata,
    output logic [N-1:0]        m_wait
);
    logic [ADDR_W-1:0] addr_term [N];
    logic [DATA_W-1:0] data_term [N];

    for (genvar i = 0; i < N; i++) begin : g_port
        assign addr_term[i] = gnt[i] ? m_addr[i*ADDR_W +: ADDR_W] : '0;
        assign data_term[i] = gnt[i] ? m_wdata[i*DATA_W +: DATA_W] : '0;
        assign m_rdata[i*DATA_W +: DATA_W] = gnt[i] ? s_rdata : '0;
        assign m_wait[i] = ~(gnt[i] & xfer_done);
    end

    always_comb begin
        s_addr  = '0;
        s_wdata = '0;
        for (int i = 0; i < N; i++) begin
            s_addr  = s_addr | addr_term[i];
            s_wdata = s_wdata | data_term[i];
        end
    end
endmodule

// File: rtl/reg_access_arbiter.sv
module reg_access_arbiter
    import arb_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 32
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [NUM_M-1:0]        m_enable,
    input  logic [NUM_M-1:0]        m_read,
    input  logic [NUM_M-1:0]        m_write,
    input  logic [NUM_M*ADDR_W-1:0] m_addr,
    input  logic [NUM_M*DATA_W-1:0] m_wdata,
    output logic [NUM_M*DATA_W-1:0] m_rdata,
    output logic [NUM_M-1:0]        m_wait,
    input  logic                    cal_owns,
    input  logic                    handback_req,
    output logic                    handback_ack,
    output logic [ADDR_W-1:0]       s_addr,
    output logic [DATA_W-1:0]       s_wdata,
    output logic                    s_read,
    output logic                    s_write,
    input  logic [DATA_W-1:0]       s_rdata,
    input  logic                    s_rvalid,
    input  logic                    s_wait
);
    arb_regs_t        r_d, r_q;
    logic [NUM_M-1:0] req_live;
    logic [NUM_M-1:0] pick;
    logic             busy;
    logic             xfer_done;
    logic             may_grant;
    logic [NUM_M-1:0] gnt_q;

    assign req_live  = (m_read | m_write) & m_enable;
    assign busy      = (r_q.state == ST_BUSY);
    assign gnt_q     = r_q.gnt;
    assign s_write   = busy & r_q.op_wr;
    assign s_read    = busy & ~r_q.op_wr;
    assign xfer_done = busy & (r_q.op_wr ? ~s_wait : s_rvalid);
    assign may_grant = ~cal_owns & ~handback_req;
    assign handback_ack = r_q.ack;

    arb_prio_pick #(.N(NUM_M)) u_pick (
        .req  (req_live),
        .pick (pick)
    );

    arb_port_mux #(.N(NUM_M), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mux (
        .gnt       (r_q.gnt),
        .xfer_done (xfer_done),
        .m_addr    (m_addr),
        .m_wdata   (m_wdata),
        .s_rdata   (s_rdata),
        .s_addr    (s_addr),
        .s_wdata   (s_wdata),
        .m_rdata   (m_rdata),
        .m_wait    (m_wait)
    );

    always_comb begin
        r_d     = r_q;
        r_d.ack = handback_req & (r_q.state == ST_IDLE);
        unique case (r_q.state)
            ST_IDLE: begin
                if (may_grant && (|req_live)) begin
                    r_d.state = ST_BUSY;
                    r_d.gnt   = pick;
                    r_d.op_wr = |(pick & m_write);
                end
            end
            ST_BUSY: begin
                if (xfer_done) begin
                    r_d.state = ST_IDLE;
                    r_d.gnt   = '0;
                    r_d.op_wr = 1'b0;
                end
            end
            default: r_d = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end
endmodule

// File: rtl/reg_access_arbiter_chk.sv
module reg_access_arbiter_chk #(
    parameter int N = 3
) (
    input logic         clk,
    input logic         rst,
    input logic         cal_owns,
    input logic         handback_ack,
    input logic [N-1:0] m_enable,
    input logic [N-1:0] m_wait,
    input logic [N-1:0] gnt,
    input logic         s_read,
    input logic         s_write,
    input logic         done
);
    logic active;
    assign active = s_read | s_write;

    a_r10_one_grant: assert property (@(posedge clk) disable iff (rst)
        $onehot0(gnt));

    a_r6_wait_low_only_on_done: assert property (@(posedge clk) disable iff (rst)
        (~m_wait != '0) |-> done);

    a_r2_grant_held: assert property (@(posedge clk) disable iff (rst)
        (active && !done) |=> ($stable(gnt) && active));

    a_r6_release_after_done: assert property (@(posedge clk) disable iff (rst)
        done |=> !active);

    a_r5_ack_only_idle: assert property (@(posedge clk) disable iff (rst)
        handback_ack |-> !active);

    a_r3_no_start_under_cal: assert property (@(posedge clk) disable iff (rst)
        $rose(active) |-> !$past(cal_owns));

    a_r4_start_enabled_only: assert property (@(posedge clk) disable iff (rst)
        $rose(active) |-> ((gnt & $past(m_enable)) != '0));
endmodule

bind reg_access_arbiter reg_access_arbiter_chk #(.N(arb_pkg::NUM_M)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .cal_owns     (cal_owns),
    .handback_ack (handback_ack),
    .m_enable     (m_enable),
    .m_wait       (m_wait),
    .gnt          (gnt_q),
    .s_read       (s_read),
    .s_write      (s_write),
    .done         (xfer_done)
);

// File: tb/tb_reg_access_arbiter.sv
module tb_reg_access_arbiter;
    localparam int AW = 10;
    localparam int DW = 32;
    localparam logic [AW-1:0] A0 = 10'h011, A1 = 10'h122, A2 = 10'h233;
    localparam logic [DW-1:0] W0 = 32'h1111_0000, W1 = 32'h2222_0000, W2 = 32'h3333_0000;

    logic clk = 1'b0;
    logic rst;
    logic [2:0] m_enable, m_read, m_write, m_wait;
    logic [3*AW-1:0] m_addr;
    logic [3*DW-1:0] m_wdata, m_rdata;
    logic cal_owns, handback_req, handback_ack;
    logic [AW-1:0] s_addr;
    logic [DW-1:0] s_wdata, s_rdata;
    logic s_read, s_write, s_rvalid, s_wait;
    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    reg_access_arbiter #(.ADDR_W(AW), .DATA_W(DW)) dut (
        .clk(clk), .rst(rst), .m_enable(m_enable), .m_read(m_read),
        .m_write(m_write), .m_addr(m_addr), .m_wdata(m_wdata),
        .m_rdata(m_rdata), .m_wait(m_wait), .cal_owns(cal_owns),
        .handback_req(handback_req), .handback_ack(handback_ack),
        .s_addr(s_addr), .s_wdata(s_wdata), .s_read(s_read),
        .s_write(s_write), .s_rdata(s_rdata), .s_rvalid(s_rvalid),
        .s_wait(s_wait)
    );

    typedef struct packed {
        logic [2:0] en, rd, wr;
        logic       cal, hb, sw, rv;
        logic [2:0] mw;
        logic       srd, swr;
        logic [1:0] asel;
        logic       ack;
        logic [3:0] rq;
    } vec_t;

    localparam int NV = 24;
    localparam vec_t TBL [NV] = '{
        '{3'b111,3'b000,3'b000,1'b0,1'b0,1'b0,1'b0, 3'b111,1'b0,1'b0,2'd0,1'b0, 4'd9},  // R9 idle
        '{3'b111,3'b100,3'b010,1'b0,1'b0,1'b1,1'b0, 3'b111,1'b0,1'b0,2'd0,1'b0, 4'd1},  // R1 collision
        '{3'b111,3'b100,3'b010,1'b0,1'b0,1'b1,1'b0, 3'b111,1'b0,1'b1,2'd2,1'b0, 4'd1},  // R1 m1 wins
        '{3'b111,3'b100,3'b011,1'b0,1'b0,1'b0,1'b0, 3'b101,1'b0,1'b1,2'd2,1'b0, 4'd2},  // R2 m0 waits
        '{3'b111,3'b100,3'b001,1'b0,1'b0,1'b0,1'b0, 3'b111,1'b0,1'b0,2'd0,1'b0, 4'd6},  // R6 release
        '{3'b111,3'b100,3'b001,1'b0,1'b0,1'b0,1'b0, 3'b110,1'b0,1'b1,2'd1,1'b0, 4'd8},  // R8 m0 next
        '{3'b111,3'b100,3'b000,1'b0,1'b0,1'b0,1'b0, 3'b111,1'b0,1'b0,2'd0,1'b0, 4'd6},  // R6
        '{3'b111,3'b100,3'b001,1'b0,1'b0,1'b1,1'b0, 3'b111,1'b1,1'b0,2'd3,1'b0, 4'd2},  // R2 m2 read held
        '{3'b111,3'b100,3'b001,1'b0,1'b0,1'b0,1'b1, 3'b011,1'b1,1'b0,2'd3,1'b0, 4'd6},  // R6 read done
        '{3'b111,3'b000,3'b001,1'b0,1'b0,1'b0,1'b0, 3'b111,1'b0,1'b0,2'd0,1'b0, 4'd6},  // R6
        '{3'b111,3'b000,3'b001,1'b0,1'b0,1'b0,1'b0, 3'b110,1'b0,1'b1,2'd1,1'b0, 4'd2},  // R2 m0 served
        '{3'b011,3'b100,3'b000,1'b0,1'b0,1'b0,1'b0, 3'b111,1'b0,1'b0,2'd0,1'b0, 4'd4},  // R4
        '{3'b011,3'b100,3'b000,1'b0,1'b0,1'b0,1'b0, 3'b111,1'b0,1'b0,2'd0,1'b0, 4'd4},  // R4 no grant
        '{3'b111,3'b000,3'b000,1'b0,1'b0,1'b0,1'b0, 3'b111,1'b0,1'b0,2'd0,1'b0, 4'd4},  // R4
        '{3'b111,3'b000,3'b010,1'b1,1'b0,1'b0,1'b0, 3'b111,1'b0,1'b0,2'd0,1'b0, 4'd3},  // R3
        '{3'b111,3'b000,3'b010,1'b1,1'b0,1'b0,1'b0, 3'b111,1'b0,1'b0,2'd0,1'b0, 4'd3},  // R3 stalled
        '{3'b111,3'b000,3'b010,1'b0,1'b0,1'b1,1'b0, 3'b111,1'b0,1'b0,2'd0,1'b0, 4'd3},  // R3 freed
        '{3'b111,3'b000,3'b010,1'b0,1'b1,1'b1,1'b0, 3'b111,1'b0,1'b1,2'd2,1'b0, 4'd5},  // R5 busy, no ack
        '{3'b111,3'b000,3'b010,1'b0,1'b1,1'b0,1'b0, 3'b101,1'b0,1'b1,2'd2,1'b0, 4'd5},  // R5
        '{3'b111,3'b000,3'b001,1'b0,1'b1,1'b0,1'b0, 3'b111,1'b0,1'b0,2'd0,1'b0, 4'd5},  // R5 no grant
        '{3'b111,3'b000,3'b001,1'b0,1'b1,1'b0,1'b0, 3'b111,1'b0,1'b0,2'd0,1'b1, 4'd5},  // R5 ack
        '{3'b111,3'b000,3'b001,1'b0,1'b0,1'b0,1'b0, 3'b111,1'b0,1'b0,2'd0,1'b1, 4'd5},  // R5 ack lingers
        '{3'b111,3'b000,3'b001,1'b0,1'b0,1'b0,1'b0, 3'b110,1'b0,1'b1,2'd1,1'b0, 4'd5},  // R5 ack drops
        '{3'b111,3'b000,3'b000,1'b0,1'b0,1'b0,1'b0, 3'b111,1'b0,1'b0,2'd0,1'b0, 4'd6}   // R6
    };

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    function automatic logic [AW-1:0] addr_of(input logic [1:0] sel);
        case (sel)
            2'd1: return A0;
            2'd2: return A1;
            2'd3: return A2;
            default: return '0;
        endcase
    endfunction

    function automatic logic [DW-1:0] data_of(input logic [1:0] sel);
        case (sel)
            2'd1: return W0;
            2'd2: return W1;
            2'd3: return W2;
            default: return '0;
        endcase
    endfunction

    initial begin
        repeat (5000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: run did not end, actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst = 1'b1;
        m_enable = 3'b111; m_read = '0; m_write = '0;
        m_addr  = {A2, A1, A0};
        m_wdata = {W2, W1, W0};
        cal_owns = 1'b0; handback_req = 1'b0;
        s_rdata = 32'hDEAD_BEEF; s_rvalid = 1'b0; s_wait = 1'b0;
        repeat (3) tick();
        // R9: state while reset is held
        #2;
        chk("R9 reset m_wait", 64'(m_wait), 64'(3'b111));
        chk("R9 reset ack", 64'(handback_ack), 64'd0);
        chk("R9 reset strobes", 64'({s_read, s_write}), 64'd0);
        tick();
        rst = 1'b0;

        for (int v = 0; v < NV; v++) begin
            m_enable = TBL[v].en; m_read = TBL[v].rd; m_write = TBL[v].wr;
            cal_owns = TBL[v].cal; handback_req = TBL[v].hb;
            s_wait = TBL[v].sw; s_rvalid = TBL[v].rv;
            #2;
            chk($sformatf("R%0d row %0d m_wait", TBL[v].rq, v), 64'(m_wait), 64'(TBL[v].mw));
            chk($sformatf("R%0d row %0d s_read", TBL[v].rq, v), 64'(s_read), 64'(TBL[v].srd));
            chk($sformatf("R%0d row %0d s_write", TBL[v].rq, v), 64'(s_write), 64'(TBL[v].swr));
            // R10 address and write data follow the grant
            chk($sformatf("R10 row %0d s_addr", v), 64'(s_addr), 64'(addr_of(TBL[v].asel)));
            chk($sformatf("R10 row %0d s_wdata", v), 64'(s_wdata), 64'(data_of(TBL[v].asel)));
            chk($sformatf("R%0d row %0d ack", TBL[v].rq, v), 64'(handback_ack), 64'(TBL[v].ack));
            tick();
        end

        // R7: read data reaches only the granted master (m1)
        m_enable = 3'b111; m_read = 3'b010; m_write = '0;
        cal_owns = 1'b0; handback_req = 1'b0; s_wait = 1'b1; s_rvalid = 1'b0;
        tick();
        s_rvalid = 1'b1; s_rdata = 32'h5A5A_1234;
        #2;
        chk("R7 m1 rdata", 64'(m_rdata[DW +: DW]), 64'(32'h5A5A_1234));
        chk("R7 m0 rdata", 64'(m_rdata[0 +: DW]), 64'd0);
        chk("R7 m2 rdata", 64'(m_rdata[2*DW +: DW]), 64'd0);
        chk("R6 m1 read done wait", 64'(m_wait), 64'(3'b101));
        tick();
        m_read = '0; s_rvalid = 1'b0;
        tick();

        // R10: read and write together performs the write
        m_read = 3'b100; m_write = 3'b100; s_wait = 1'b1;
        tick();
        #2;
        chk("R10 rd+wr gives write", 64'({s_read, s_write}), 64'(2'b01));
        // R9: reset in the middle of an access
        rst = 1'b1;
        tick();
        #2;
        chk("R9 mid reset m_wait", 64'(m_wait), 64'(3'b111));
        chk("R9 mid reset strobes", 64'({s_read, s_write}), 64'd0);
        chk("R9 mid reset addr", 64'(s_addr), 64'd0);
        rst = 1'b0;
        m_read = '0; m_write = '0;
        tick();
        #2;
        chk("R9 idle after reset", 64'({s_read, s_write}), 64'd0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule